// File: doc/BRIEF.md
# T=1 Block Frame Checker

This block follows the received byte stream of an asynchronous half-duplex block protocol and works out where each byte sits in its block. A block opens with a node address byte, a protocol control byte and a length byte. That prologue is followed by as many information bytes as the length byte states, and the block closes with an error-detection field. The checker tags every accepted byte with its field and reports the end of each block. It also reports length faults, a longitudinal redundancy (XOR) mismatch and per-character parity faults.

The checker sits after the character decoder. Each decoded byte arrives with its own parity-error flag. An upstream timer, such as a character-waiting timeout, raises `blk_end_i` when the line falls silent. The EDC mode input selects one of two closing fields:
- a one-byte XOR check, which the hardware checks;
- a two-byte CRC, which the hardware only counts and leaves to software to check.

The checker does not judge the meaning of the protocol control byte.

The controller has six states:
- **AWAIT_NAD**: idle, waiting for the address byte.
- **GOT_NAD**: waiting for the protocol control byte.
- **GOT_PCB**: waiting for the length byte.
- **IN_INF**: counting information bytes.
- **IN_EDC**: counting EDC bytes.
- **DISCARD**: dropping the rest of a block whose length byte is invalid.

The transitions are:
- **T_ADDR**: AWAIT_NAD→GOT_NAD on any byte.
- **T_CTRL**: GOT_NAD→GOT_PCB on any byte.
- **T_LEN_BODY**: GOT_PCB→IN_INF when the length byte is 1..254.
- **T_LEN_EMPTY**: GOT_PCB→IN_EDC when the length byte is 0.
- **T_LEN_BAD**: GOT_PCB→DISCARD when the length byte is 255.
- **T_BODY_DONE**: IN_INF→IN_EDC on the last information byte.
- **T_CLOSE**: IN_EDC→AWAIT_NAD on the last EDC byte.
- **T_SHORT**: any of GOT_NAD, GOT_PCB, IN_INF or IN_EDC →AWAIT_NAD on `blk_end_i`.
- **T_FLUSH**: DISCARD→AWAIT_NAD on `blk_end_i`.
- **T_ABORT**: any state→AWAIT_NAD on `abort_i`.

Top module: `t1_frame_check`

## Requirements
- R1: After reset the checker is in AWAIT_NAD, and every output (`tag_vld_o`, `field_o`, `done_o`, `len_err_o`, `edc_err_o`, `par_err_o`) is 0.
- R2: Each accepted byte (`byte_vld_i`=1 and `abort_i`=0) raises `tag_vld_o` in the next cycle. In that cycle `field_o` holds the byte's field:
  - 0 for the address byte;
  - 1 for the control byte;
  - 2 for the length byte;
  - 3 for an information byte;
  - 4 for an EDC byte;
  - 5 for a discarded byte.

  The fields come in the order address, control, length, then exactly LEN information bytes, then the EDC field.
- R3: A length byte of 0 is followed directly by the EDC field, with no information bytes.
- R4: With `edc_crc_i`=0 the EDC field is one byte. `edc_err_o` rises together with `done_o` exactly when the XOR of all the block's bytes, the EDC byte included, is nonzero.
- R5: With `edc_crc_i`=1 the EDC field is two bytes, and `edc_err_o` stays 0.
- R6: `done_o` pulses for one cycle, in the cycle after the last EDC byte. The next accepted byte is tagged as an address byte.
- R7: A length byte of 255 pulses `len_err_o` in the next cycle. The following bytes are tagged 5, with no `done_o`, until `blk_end_i`. After that the next byte is an address byte.
- R8: `blk_end_i` with `byte_vld_i`=0 while a block is open (any state from GOT_NAD through IN_EDC) pulses `len_err_o` in the next cycle and returns the checker to AWAIT_NAD. In AWAIT_NAD, `blk_end_i` has no effect.
- R9: A byte accepted with `par_err_i`=1 pulses `par_err_o` in the next cycle, in any field. This report sits alongside the XOR check and does not replace it.
- R10: `abort_i` wins over a byte in the same cycle. That byte is not tagged, no flag rises, and the next byte is an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Drop the current block and await an address byte |
| edc_crc_i | input | 1 | 0: one-byte XOR check; 1: two-byte CRC field, not checked |
| byte_vld_i | input | 1 | A decoded byte is present |
| byte_i | input | BYTE_W | Decoded byte |
| par_err_i | input | 1 | Parity fault on this byte |
| blk_end_i | input | 1 | Line-level end of block, sampled only while `byte_vld_i`=0 |
| tag_vld_o | output | 1 | `field_o` is valid for the byte accepted in the previous cycle |
| field_o | output | 3 | Field code of that byte |
| done_o | output | 1 | The block closed with its last EDC byte |
| len_err_o | output | 1 | Invalid length byte, or the block ended early |
| edc_err_o | output | 1 | XOR check failed |
| par_err_o | output | 1 | The byte accepted in the previous cycle had a parity fault |

## Verification
The assertions rely on a few things about the inputs:
- `edc_crc_i` is held steady for the whole of a block.
- `blk_end_i` is never raised in the same cycle as a byte.
- The block length is not cut short by anything other than `blk_end_i` or `abort_i`.

The stimulus respects these. It changes the mode only between blocks and raises `blk_end_i` only in idle cycles. It sweeps information lengths 0 to 20 and 254 in both EDC modes, with good and corrupted XOR bytes and with a parity fault placed on a different byte each time. Directed sequences then cover an invalid length, early ends in every open state, and an abort that coincides with a byte.

// File: rtl/t1fc_pkg.sv
package t1fc_pkg;
    typedef enum logic [2:0] {
        ST_AWAIT_NAD = 3'd0,
        ST_GOT_NAD   = 3'd1,
        ST_GOT_PCB   = 3'd2,
        ST_IN_INF    = 3'd3,
        ST_IN_EDC    = 3'd4,
        ST_DISCARD   = 3'd5
    } state_e;

    typedef enum logic [2:0] {
        FLD_NAD  = 3'd0,
        FLD_PCB  = 3'd1,
        FLD_LEN  = 3'd2,
        FLD_INF  = 3'd3,
        FLD_EDC  = 3'd4,
        FLD_SKIP = 3'd5
    } field_e;
endpackage

// File: rtl/t1fc_cnt.sv
module t1fc_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (dec)    cnt <= cnt - 1'b1;
    end

    assign last_o = (cnt == W'(1));

    // R2: the remaining-byte count never wraps below zero
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr) |-> (cnt != '0));
endmodule

// File: rtl/t1fc_lrc.sv
module t1fc_lrc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         zero_o
);
    logic [W-1:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n)          acc <= '0;
        else if (en && start) acc <= din;
        else if (en)          acc <= acc ^ din;
    end

    // XOR over the block including the byte now on din
    assign zero_o = ((acc ^ din) == '0);
endmodule

// File: rtl/t1_frame_check.sv
module t1_frame_check
    import t1fc_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int CRC_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              edc_crc_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              par_err_i,
    input  logic              blk_end_i,
    output logic              tag_vld_o,
    output logic [2:0]        field_o,
    output logic              done_o,
    output logic              len_err_o,
    output logic              edc_err_o,
    output logic              par_err_o
);
    localparam logic [BYTE_W-1:0] LEN_BAD  = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] EDC_LRC  = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] EDC_CRC  = BYTE_W'(CRC_BYTES);

    state_e            st, nxt;
    field_e            fld;
    logic              take, ended;
    logic              cnt_load, cnt_dec, cnt_last;
    logic [BYTE_W-1:0] cnt_val, edc_len;
    logic              lrc_zero;
    logic              fin, lerr, eerr;

    assign take    = byte_vld_i && !abort_i;
    assign ended   = blk_end_i && !byte_vld_i && !abort_i;
    assign edc_len = edc_crc_i ? EDC_CRC : EDC_LRC;

    t1fc_cnt #(.W(BYTE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (abort_i),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last_o   (cnt_last)
    );

    t1fc_lrc #(.W(BYTE_W)) u_lrc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (take),
        .start  (st == ST_AWAIT_NAD),
        .din    (byte_i),
        .zero_o (lrc_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_AWAIT_NAD;
        else        st <= nxt;
    end

    // transitions and per-byte decisions
    always_comb begin
        nxt      = st;
        fld      = FLD_NAD;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        fin      = 1'b0;
        lerr     = 1'b0;
        eerr     = 1'b0;
        if (abort_i) begin
            nxt = ST_AWAIT_NAD;                       // T_ABORT
        end else if (take) begin
            unique case (st)
                ST_AWAIT_NAD: begin fld = FLD_NAD; nxt = ST_GOT_NAD; end
                ST_GOT_NAD:   begin fld = FLD_PCB; nxt = ST_GOT_PCB; end
                ST_GOT_PCB: begin
                    fld = FLD_LEN;
                    if (byte_i == LEN_BAD) begin
                        lerr = 1'b1;
                        nxt  = ST_DISCARD;            // T_LEN_BAD
                    end else if (byte_i == '0) begin
                        cnt_load = 1'b1;
                        cnt_val  = edc_len;
                        nxt      = ST_IN_EDC;         // T_LEN_EMPTY
                    end else begin
                        cnt_load = 1'b1;
                        cnt_val  = byte_i;
                        nxt      = ST_IN_INF;         // T_LEN_BODY
                    end
                end
                ST_IN_INF: begin
                    fld = FLD_INF;
                    if (cnt_last) begin
                        cnt_load = 1'b1;
                        cnt_val  = edc_len;
                        nxt      = ST_IN_EDC;         // T_BODY_DONE
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                ST_IN_EDC: begin
                    fld = FLD_EDC;
                    if (cnt_last) begin
                        fin  = 1'b1;
                        eerr = !edc_crc_i && !lrc_zero;
                        nxt  = ST_AWAIT_NAD;          // T_CLOSE
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                ST_DISCARD: fld = FLD_SKIP;
                default:    nxt = ST_AWAIT_NAD;
            endcase
        end else if (ended) begin
            if (st == ST_DISCARD) begin
                nxt = ST_AWAIT_NAD;                   // T_FLUSH
            end else if (st != ST_AWAIT_NAD) begin
                lerr = 1'b1;
                nxt  = ST_AWAIT_NAD;                  // T_SHORT
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_vld_o <= 1'b0;
            field_o   <= 3'd0;
            done_o    <= 1'b0;
            len_err_o <= 1'b0;
            edc_err_o <= 1'b0;
            par_err_o <= 1'b0;
        end else begin
            tag_vld_o <= take;
            field_o   <= take ? fld : 3'd0;
            done_o    <= fin;
            len_err_o <= lerr;
            edc_err_o <= eerr;
            par_err_o <= take && par_err_i;
        end
    end

    // R6: a block cannot both close and fail its length
    a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && len_err_o));
    // R4: an XOR failure is reported only when a block closes
    a_r4_edc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        edc_err_o |-> done_o);
    // R5: an EDC byte seen in CRC mode never yields an XOR failure
    a_r5_crc_no_edc: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st == ST_IN_EDC && edc_crc_i) |=> !edc_err_o);
    // R10: abort leaves nothing flagged and returns to the idle state
    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!tag_vld_o && !done_o && !len_err_o && st == ST_AWAIT_NAD));
    // R2: a tag follows only from a byte in the previous cycle
    a_r2_tag_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        tag_vld_o |-> $past(byte_vld_i));
    // R7: a block in discard never reports completion
    a_r7_no_done_skip: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(st) == ST_IN_EDC);
    // R9: a parity report belongs to a tagged byte
    a_r9_par_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> tag_vld_o);
endmodule

// File: tb/test_t1_frame_check.sv
module test_t1_frame_check;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       abort_i, edc_crc_i, byte_vld_i, par_err_i, blk_end_i;
    logic [7:0] byte_i;
    logic       tag_vld_o, done_o, len_err_o, edc_err_o, par_err_o;
    logic [2:0] field_o;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] blk [0:259];

    always #5 clk = ~clk;

    t1_frame_check i_t1_frame_check (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .edc_crc_i(edc_crc_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .par_err_i(par_err_i),
        .blk_end_i(blk_end_i), .tag_vld_o(tag_vld_o), .field_o(field_o),
        .done_o(done_o), .len_err_o(len_err_o), .edc_err_o(edc_err_o),
        .par_err_o(par_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one byte; outputs checked right after the capturing edge
    task automatic send(input logic [7:0] b, input logic pe, input int efld,
                        input int edone, input int eedc, input int elen,
                        input string rf, input string rd, input string re);
        byte_vld_i = 1'b1; byte_i = b; par_err_i = pe;
        @(posedge clk); #1;
        chk({rf, " tag_vld"}, tag_vld_o, 1);
        chk({rf, " field"}, field_o, efld);
        chk({rd, " done"}, done_o, edone);
        chk({re, " edc_err"}, edc_err_o, eedc);
        chk("R7/R8 len_err", len_err_o, elen);
        chk("R9 par_err", par_err_o, pe);
        @(negedge clk);
        byte_vld_i = 1'b0; par_err_i = 1'b0;
    endtask

    task automatic end_pulse(input int elen, input string r);
        blk_end_i = 1'b1;
        @(posedge clk); #1;
        chk({r, " len_err on end"}, len_err_o, elen);
        chk({r, " no tag on end"}, tag_vld_o, 0);
        @(negedge clk);
        blk_end_i = 1'b0;
    endtask

    task automatic send_block(input int len, input logic crc, input logic bad,
                              input int perr_at);
        int n;
        logic [7:0] x;
        n = 3 + len + (crc ? 2 : 1);
        edc_crc_i = crc;
        blk[0] = 8'h5A ^ 8'(len);
        blk[1] = 8'h40 | 8'(len & 7);
        blk[2] = 8'(len);
        x = blk[0] ^ blk[1] ^ blk[2];
        for (int k = 0; k < len; k++) begin
            blk[3 + k] = 8'((k * 37 + len * 11 + 3) & 255);
            x = x ^ blk[3 + k];
        end
        if (crc) begin
            blk[3 + len] = 8'hC3;
            blk[4 + len] = 8'h3C;
        end else begin
            blk[3 + len] = bad ? (x ^ 8'h01) : x;
        end
        for (int i = 0; i < n; i++) begin
            int   f;
            logic last;
            last = (i == n - 1);
            if (i < 3)             f = i;
            else if (i < 3 + len)  f = 3;
            else                   f = 4;
            send(blk[i], (i == perr_at), f, last, (last && bad && !crc), 0,
                 (len == 0 && i == 3) ? "R3" : "R2", "R6", crc ? "R5" : "R4");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        rst_n = 1'b0; abort_i = 1'b0; edc_crc_i = 1'b0; byte_vld_i = 1'b0;
        byte_i = 8'h00; par_err_i = 1'b0; blk_end_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 tag_vld", tag_vld_o, 0);
        chk("R1 field", field_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 len_err", len_err_o, 0);
        chk("R1 edc_err", edc_err_o, 0);
        chk("R1 par_err", par_err_o, 0);
        @(negedge clk);

        // sweep of lengths, modes, XOR corruption and parity placement
        for (int crc = 0; crc < 2; crc++) begin
            for (int len = 0; len <= 21; len++) begin
                for (int bad = 0; bad < 2; bad++) begin
                    int l;
                    l = (len == 21) ? 254 : len;
                    send_block(l, crc[0], bad[0], (l + bad * 2) % (l + 4));
                end
            end
        end

        // R7 invalid length then discard until end
        edc_crc_i = 1'b0;
        send(8'h00, 1'b0, 0, 0, 0, 0, "R7", "R6", "R4");
        send(8'h01, 1'b0, 1, 0, 0, 0, "R7", "R6", "R4");
        send(8'hFF, 1'b0, 2, 0, 0, 1, "R7", "R6", "R4");
        for (int k = 0; k < 4; k++)
            send(8'(k), 1'b0, 5, 0, 0, 0, "R7", "R7", "R7");
        end_pulse(0, "R7");
        send_block(2, 1'b0, 1'b0, -1);

        // R8 early end in each open state, none when idle
        end_pulse(0, "R8");
        for (int depth = 1; depth <= 5; depth++) begin
            send(8'h11, 1'b0, 0, 0, 0, 0, "R8", "R6", "R4");
            if (depth > 1) send(8'h22, 1'b0, 1, 0, 0, 0, "R8", "R6", "R4");
            if (depth > 2) send(8'h03, 1'b0, 2, 0, 0, 0, "R8", "R6", "R4");
            if (depth > 3) send(8'h44, 1'b0, 3, 0, 0, 0, "R8", "R6", "R4");
            if (depth > 4) begin
                send(8'h55, 1'b0, 3, 0, 0, 0, "R8", "R6", "R4");
                send(8'h66, 1'b0, 3, 0, 0, 0, "R8", "R6", "R4");
            end
            end_pulse(1, "R8");
        end
        send_block(1, 1'b0, 1'b0, -1);

        // R10 abort together with a byte, mid-block
        send(8'h11, 1'b0, 0, 0, 0, 0, "R10", "R6", "R4");
        send(8'h22, 1'b0, 1, 0, 0, 0, "R10", "R6", "R4");
        send(8'h05, 1'b0, 2, 0, 0, 0, "R10", "R6", "R4");
        abort_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h77; par_err_i = 1'b1;
        @(posedge clk); #1;
        chk("R10 tag_vld", tag_vld_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 len_err", len_err_o, 0);
        chk("R10 par_err", par_err_o, 0);
        @(negedge clk);
        abort_i = 1'b0; byte_vld_i = 1'b0; par_err_i = 1'b0;
        send_block(3, 1'b0, 1'b0, 1);
        send_block(0, 1'b1, 1'b0, -1);

        report();
    end
endmodule